// File: doc/BRIEF.md
# Bidirectional Parallel Port Register Block

This block is the host side of a PC-style parallel printer port. It sits on an 8-bit I/O bus and answers three consecutive I/O addresses above a base address set by a parameter. The lowest address is the data register. The next address is a status register that software can only read. The highest address is a control register.

One bit of the control register sets the direction of the eight data pins. When the bit is clear, the block drives the pins with its data latch, and writes to the data address appear on them. When the bit is set, the block releases the pins and samples them on every clock. A read of the data address then returns the sampled value and no longer the latch. The printer condition lines (busy, error and the rest) are registered each clock so that the host can read them at the status address.

The actual tri-state pad sits outside the block. The block supplies the output value, an output enable and the sampled input. Reads are combinational: the read data bus is driven only while a read hits one of the three registers. Writes take effect at the clock edge.

Top module: `par_port_regs`

## Requirements
- R1: With parameter `BASE_ADDR` (default 'h378; 'h278 for a secondary port), the data register answers at BASE_ADDR, the status register at BASE_ADDR+1 and the control register at BASE_ADDR+2. A read hitting one of these addresses asserts `rd_en_o` in the same cycle.
- R2: A read of the status address returns `stat_i` as captured at the previous rising clock edge. A write to the status address changes neither the data latch nor the control register.
- R3: While control bit 5 (`DIR_BIT`, value 20h) is 1, a read of the data address returns `pd_i` as captured at the previous rising clock edge.
- R4: `pd_o` always carries the data latch. A write to the data address is visible on `pd_o` from the cycle after its clock edge.
- R5: `pd_oe_o` is 1 exactly when control bit 5 is 0 and the block is out of reset. Writing a control value with bit 5 set releases the pins from the next cycle.
- R6: While control bit 5 is 0, a read of the data address returns the last value written to the data address. The latch also accepts writes while bit 5 is 1.
- R7: All eight control bits are stored on a write to the control address and read back unchanged.
- R8: An access to any address other than the three registers changes no state. `rd_en_o` is 0 and `rd_data_o` is 00h whenever no read hits a register.
- R9: Reset (`rst_ni` low, asynchronous) clears the control register and the data latch to 00h. The port therefore comes out of reset in output mode, driving 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | I/O address |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data, 00h when not enabled |
| rd_en_o | output | 1 | Read data bus enable |
| pd_i | input | 8 | Data pins as seen at the pad |
| pd_o | output | 8 | Value to drive onto the data pins |
| pd_oe_o | output | 1 | Pin output enable |
| stat_i | input | 8 | Printer condition lines |

## Verification
The bench builds the block with `ADDR_W` = 10 and `BASE_ADDR` = 'h278, the secondary base. With these values the primary addresses 'h378 to 'h37A are legal bus addresses that must miss, and the words just below and just above the window (base-1 and base+3) are also exercised as misses. Directed steps cover the direction switch in both directions, a data write made in input mode, and the one-clock capture delay on pins and status. A random phase then mixes reads, writes and simultaneous read-write over all of these addresses, and a behavioural model is compared with the outputs on every cycle.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 3;
  typedef logic [BYTE_W-1:0] byte_t;
  // register index = offset from the base address
  typedef enum int {
    REG_DATA = 0,
    REG_STAT = 1,
    REG_CTRL = 2
  } reg_idx_e;
endpackage

// File: rtl/pp_addr_dec.sv
module pp_addr_dec
  import pp_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 'h378
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] hit_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
    localparam logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(BASE_ADDR + g);
    assign hit_o[g] = (addr_i == REG_ADDR);
  end
endmodule

// File: rtl/pp_capture.sv
module pp_capture #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/pp_port_regs.sv
module pp_port_regs
  import pp_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  byte_t               wdata_i,
  input  logic [NUM_REGS-1:0] hit_i,
  output byte_t               data_q_o,
  output byte_t               ctrl_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q_o <= '0;
      ctrl_q_o <= '0;
    end else if (wr_i) begin
      if (hit_i[REG_DATA]) data_q_o <= wdata_i;
      if (hit_i[REG_CTRL]) ctrl_q_o <= wdata_i;
    end
  end

  AST_NO_STRAY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !hit_i[REG_DATA] && !hit_i[REG_CTRL]) |=> ($stable(data_q_o) && $stable(ctrl_q_o))); // R8
  AST_CTRL_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit_i[REG_CTRL]) |=> (ctrl_q_o == $past(wdata_i))); // R7
endmodule

// File: rtl/par_port_regs.sv
module par_port_regs
  import pp_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 'h378,
  parameter int DIR_BIT   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_en_o,
  input  logic [7:0]        pd_i,
  output logic [7:0]        pd_o,
  output logic              pd_oe_o,
  input  logic [7:0]        stat_i
);
  logic [NUM_REGS-1:0] hit;
  byte_t data_q, ctrl_q, pin_q, stat_q;
  logic  dir_in;

  pp_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr_i (addr_i),
    .hit_o  (hit)
  );

  pp_capture #(.W(BYTE_W)) u_pin_cap (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (pd_i), .q_o (pin_q)
  );

  pp_capture #(.W(BYTE_W)) u_stat_cap (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (stat_i), .q_o (stat_q)
  );

  pp_port_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_i),
    .wdata_i  (wdata_i),
    .hit_i    (hit),
    .data_q_o (data_q),
    .ctrl_q_o (ctrl_q)
  );

  assign dir_in  = ctrl_q[DIR_BIT];
  assign pd_o    = data_q;
  assign pd_oe_o = rst_ni && !dir_in;
  assign rd_en_o = rd_i && (|hit);

  always_comb begin
    rd_data_o = '0;
    if (rd_i) begin
      if (hit[REG_DATA]) rd_data_o = dir_in ? pin_q : data_q;
      if (hit[REG_STAT]) rd_data_o = stat_q;
      if (hit[REG_CTRL]) rd_data_o = ctrl_q;
    end
  end

  AST_ONE_REG_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit)); // R1
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_o |-> (rd_data_o == 8'h00)); // R8
  AST_DIR_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit[REG_CTRL] && wdata_i[DIR_BIT]) |=> !pd_oe_o); // R5
  AST_LATCH_TO_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit[REG_DATA]) |=> (pd_o == $past(wdata_i))); // R4
  AST_STATUS_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit[REG_STAT]) |=> ($stable(pd_o) && $stable(pd_oe_o))); // R2
endmodule

// File: tb/par_port_regs_tb.sv
module par_port_regs_tb;
  localparam int AW   = 10;
  localparam int BASE = 'h278;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [7:0]    wdata = '0, pd_in = '0, stat = '0;
  logic [7:0]    rd_data, pd_out;
  logic          rd_en, pd_oe;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // behavioural model state
  logic [7:0] m_data = '0, m_ctrl = '0, m_pin = '0, m_stat = '0;

  always #5 clk = ~clk;

  par_port_regs #(.ADDR_W(AW), .BASE_ADDR(BASE), .DIR_BIT(5)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .wr_i (wr), .rd_i (rd),
    .wdata_i (wdata), .rd_data_o (rd_data), .rd_en_o (rd_en),
    .pd_i (pd_in), .pd_o (pd_out), .pd_oe_o (pd_oe), .stat_i (stat)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int offs(input logic [AW-1:0] a);
    return int'(a) - BASE;
  endfunction

  task automatic compare();
    int  o = offs(addr);
    bit  hit = (o >= 0) && (o <= 2);
    logic [7:0] exp_rd = 8'h00;
    string tag = "R8";
    if (rd && hit) begin
      case (o)
        0: begin exp_rd = m_ctrl[5] ? m_pin : m_data; tag = m_ctrl[5] ? "R3" : "R6"; end
        1: begin exp_rd = m_stat; tag = "R2"; end
        default: begin exp_rd = m_ctrl; tag = "R7"; end
      endcase
    end
    chk(rd_en === (rd && hit), hit ? "R1" : "R8", int'(rd_en), int'(rd && hit));
    chk(rd_data === exp_rd, tag, int'(rd_data), int'(exp_rd));
    chk(pd_oe === !m_ctrl[5], "R5", int'(pd_oe), int'(!m_ctrl[5]));
    chk(pd_out === m_data, "R4", int'(pd_out), int'(m_data));
  endtask

  // one bus cycle: drive at negedge, check settled outputs, then model the edge
  task automatic step(input logic [AW-1:0] a, input bit w, input bit r,
                      input logic [7:0] wd, input logic [7:0] pin, input logic [7:0] st);
    int o;
    @(negedge clk);
    addr = a; wr = w; rd = r; wdata = wd; pd_in = pin; stat = st;
    #2;
    compare();
    @(posedge clk);
    o = offs(a);
    if (w && o == 0) m_data = wd;
    if (w && o == 2) m_ctrl = wd;
    m_pin  = pin;
    m_stat = st;
  endtask

  initial begin : watchdog
    #200us;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    // R9 / R5: during reset pins are released and nothing is read
    #12;
    chk(pd_oe === 1'b0, "R5", int'(pd_oe), 0);
    chk(pd_out === 8'h00, "R9", int'(pd_out), 0);
    chk(rd_en === 1'b0, "R8", int'(rd_en), 0);
    @(negedge clk); rst_n = 1'b1;

    // R9: reset values read back
    step(AW'(BASE + 2), 0, 1, 8'h00, 8'h00, 8'h00);
    step(AW'(BASE + 0), 0, 1, 8'h00, 8'h00, 8'h00);
    // R4 / R6: output mode write then read back
    step(AW'(BASE + 0), 1, 0, 8'hA5, 8'h00, 8'h00);
    step(AW'(BASE + 0), 0, 1, 8'h00, 8'h66, 8'h00);
    chk(rd_data === 8'hA5, "R6", int'(rd_data), 'hA5);
    // R2: status write ignored, status captured one edge earlier
    step(AW'(BASE + 1), 1, 0, 8'hFF, 8'h00, 8'h5A);
    step(AW'(BASE + 1), 0, 1, 8'h00, 8'h00, 8'h00);
    chk(rd_data === 8'h5A, "R2", int'(rd_data), 'h5A);
    step(AW'(BASE + 2), 0, 1, 8'h00, 8'h00, 8'h00);
    chk(rd_data === 8'h00, "R2", int'(rd_data), 0);
    // R3 / R5: switch to input mode
    step(AW'(BASE + 2), 1, 0, 8'h20, 8'h3C, 8'h00);
    chk(pd_oe === 1'b1, "R5", int'(pd_oe), 1);
    step(AW'(BASE + 0), 0, 1, 8'h00, 8'hC3, 8'h00);
    chk(pd_oe === 1'b0, "R5", int'(pd_oe), 0);
    chk(rd_data === 8'h3C, "R3", int'(rd_data), 'h3C);
    step(AW'(BASE + 0), 0, 1, 8'h00, 8'hC3, 8'h00);
    chk(rd_data === 8'hC3, "R3", int'(rd_data), 'hC3);
    // R6: latch written in input mode shows once output mode returns
    step(AW'(BASE + 0), 1, 0, 8'h11, 8'hC3, 8'h00);
    step(AW'(BASE + 2), 1, 0, 8'h00, 8'hC3, 8'h00);
    step(AW'(BASE + 0), 0, 1, 8'h00, 8'hC3, 8'h00);
    chk(rd_data === 8'h11 && pd_oe === 1'b1, "R6", int'(rd_data), 'h11);
    // R7: other control bits kept
    step(AW'(BASE + 2), 1, 0, 8'hDF, 8'h00, 8'h00);
    step(AW'(BASE + 2), 0, 1, 8'h00, 8'h00, 8'h00);
    chk(rd_data === 8'hDF, "R7", int'(rd_data), 'hDF);
    // R8: primary-base and neighbouring addresses miss
    step(AW'('h378), 1, 1, 8'hFF, 8'h00, 8'h00);
    step(AW'('h37A), 1, 1, 8'hFF, 8'h00, 8'h00);
    step(AW'(BASE + 3), 1, 1, 8'h20, 8'h00, 8'h00);
    step(AW'(BASE - 1), 1, 1, 8'h20, 8'h00, 8'h00);
    step(AW'(BASE + 2), 0, 1, 8'h00, 8'h00, 8'h00);
    chk(rd_data === 8'hDF, "R8", int'(rd_data), 'hDF);
    step(AW'(BASE + 0), 0, 1, 8'h00, 8'h00, 8'h00);
    chk(rd_data === 8'h11, "R8", int'(rd_data), 'h11);

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom_range(0, 6);
      logic [AW-1:0] a;
      case (sel)
        0: a = AW'(BASE - 1);
        1, 2, 3: a = AW'(BASE + sel - 1);
        4: a = AW'(BASE + 3);
        5: a = AW'('h378);
        default: a = AW'(BASE + 2);
      endcase
      step(a, $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
           8'($urandom), 8'($urandom), 8'($urandom));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule